// File: doc/BRIEF.md
# Decimating Triggered Capture Buffer

This block records a stream of 12-bit converter samples into a 2048-entry circular memory for a small oscilloscope. Incoming samples arrive with a valid strobe. A programmable decimation factor thins them, so only every N-th valid sample is stored. Stored samples go to consecutive ring addresses, which wrap at the end of the ring.

Once the ring has been completely filled at least once, the block watches for a rising crossing of a programmable threshold. The sample that crosses is stored. Half a ring of further samples is then stored and capture stops. The trigger therefore sits in the middle of the saved record.

On completion the block raises a sticky completion flag and presents the address of its final write. The host reads any ring location through a separate address port. It rebuilds the time order by starting one address past the final write and wrapping around.

Top module: `capture_ring`

## Requirements
- R1: A synchronous, active-high `rst` clears the completion flag, the write position (back to address 0), the decimation phase, the filled state and the trigger state. `done` reads 0 in the cycle after the reset edge. Memory contents are left untouched.
- R2: With a decimation setting N of 2 or more, the first valid sample after reset is stored, and after it every N-th valid sample. Cycles with `in_valid` low do not advance the decimation count.
- R3: A decimation setting of 0 or 1 stores every valid sample.
- R4: Stored samples are written to consecutive addresses starting at 0, and the address wraps from 2047 back to 0.
- R5: A stored sample fires the trigger when the previously stored sample was below `trig_level` and this sample is at or above it, both compared as unsigned values.
- R6: No trigger fires before 2048 samples have been stored since reset. The triggering sample is at least the 2049th stored sample, and crossings before that point are ignored.
- R7: The triggering sample is stored, then exactly 1024 further stored samples are written, after which no further writes take place.
- R8: `done` rises in the cycle after the final write and stays high until the next reset.
- R9: While `done` is high, `last_addr` equals the address of the final write, which is the trigger address plus 1024 modulo 2048. The oldest sample is at `last_addr` plus 1 modulo 2048.
- R10: `rd_data` returns the word at `rd_addr` one clock later. A read of the address being written in the same cycle returns the previous contents of that address.
- R11: Samples presented after `done` change neither the memory nor `last_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset and re-arm, active high |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | 12 | Unsigned sample value |
| trig_level | input | 12 | Unsigned trigger threshold |
| decim | input | 11 | Decimation factor N (0 and 1 mean no decimation) |
| rd_addr | input | 11 | Host read address |
| rd_data | output | 12 | Stored word at the previous cycle's `rd_addr` |
| done | output | 1 | Capture complete, sticky until reset |
| last_addr | output | 11 | Address of the final write |

## Verification
A ring write and a host read of the same location can land on the same clock edge. To provoke this, the bench sets the read address to the current write position during a decimated capture, after the first wrap, so each stored sample overwrites the very word being read. The scoreboard takes its expected value from its model before applying that cycle's write, so only the old contents pass. It also checks the completion flag and the final address on every cycle against the model.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Effective decimation: settings below 2 keep every sample.
  function automatic int unsigned eff_factor(input int unsigned setting);
    return (setting < 2) ? 1 : setting;
  endfunction

  // Rising crossing: previous below level, current at or above it.
  function automatic bit is_rising(input int unsigned prev_v,
                                   input int unsigned cur_v,
                                   input int unsigned level);
    return (prev_v < level) && (cur_v >= level);
  endfunction

  // Next decimation phase after one valid input.
  function automatic int unsigned next_phase(input int unsigned phase,
                                             input int unsigned setting);
    return (phase + 1 >= eff_factor(setting)) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/cap_decimator.sv
module cap_decimator
  import cap_pkg::*;
#(
  parameter int DEC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DEC_W-1:0] decim,
  output logic             keep
);
  localparam int PH_W = DEC_W;

  logic [PH_W-1:0] phase_q;

  assign keep = in_valid && (phase_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (in_valid) begin
      phase_q <= PH_W'(next_phase(int'(phase_q), int'(decim)));
    end
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int AW    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             keep,
  input  logic [SMP_W-1:0] sample,
  input  logic [SMP_W-1:0] level,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             fire,
  output logic             filled,
  output logic             triggered,
  output logic             done,
  output logic [AW-1:0]    last_addr
);
  localparam int POST = 2 ** (AW - 1);

  logic [AW-1:0]    ptr_q;
  logic [AW-1:0]    last_q;
  logic [AW-1:0]    post_q;
  logic [SMP_W-1:0] prev_q;
  logic             filled_q;
  logic             trig_q;
  logic             done_q;
  logic             final_wr;

  assign wr_en     = keep && !done_q;
  assign wr_addr   = ptr_q;
  assign fire      = wr_en && filled_q && !trig_q &&
                     is_rising(int'(prev_q), int'(sample), int'(level));
  assign final_wr  = wr_en && trig_q && (post_q == AW'(POST - 1));
  assign filled    = filled_q;
  assign triggered = trig_q;
  assign done      = done_q;
  assign last_addr = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      last_q   <= '0;
      post_q   <= '0;
      prev_q   <= '0;
      filled_q <= 1'b0;
      trig_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (wr_en) begin
      ptr_q  <= ptr_q + 1'b1;
      last_q <= ptr_q;
      prev_q <= sample;
      if (&ptr_q) filled_q <= 1'b1;
      if (fire) begin
        trig_q <= 1'b1;
        post_q <= '0;
      end else if (trig_q) begin
        post_q <= post_q + 1'b1;
        if (final_wr) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cap_ring_mem.sv
module cap_ring_mem #(
  parameter int W  = 12,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/capture_ring.sv
module capture_ring #(
  parameter int SMP_W = 12,
  parameter int AW    = 11,
  parameter int DEC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SMP_W-1:0] in_sample,
  input  logic [SMP_W-1:0] trig_level,
  input  logic [DEC_W-1:0] decim,
  input  logic [AW-1:0]    rd_addr,
  output logic [SMP_W-1:0] rd_data,
  output logic             done,
  output logic [AW-1:0]    last_addr
);
  logic          keep;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          fire;
  logic          filled;
  logic          triggered;

  cap_decimator #(.DEC_W(DEC_W)) u_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .decim(decim), .keep(keep)
  );

  cap_ctrl #(.SMP_W(SMP_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .keep(keep), .sample(in_sample), .level(trig_level),
    .wr_en(wr_en), .wr_addr(wr_addr), .fire(fire), .filled(filled),
    .triggered(triggered), .done(done), .last_addr(last_addr)
  );

  cap_ring_mem #(.W(SMP_W), .AW(AW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_sample),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/capture_ring_chk.sv
module capture_ring_chk #(
  parameter int AW    = 11,
  parameter int DEC_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [DEC_W-1:0] decim,
  input logic             done,
  input logic [AW-1:0]    last_addr,
  input logic             keep,
  input logic             wr_en,
  input logic             fire,
  input logic             filled,
  input logic             triggered
);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_no_write_done_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

  assert_last_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(last_addr));

  assert_fire_after_fill_R6: assert property (@(posedge clk) disable iff (rst)
    fire |-> filled);

  assert_keep_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    keep |-> in_valid);

  assert_full_rate_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && decim < 2) |-> keep);

  assert_done_follows_trigger_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(triggered) && $past(wr_en)));
endmodule

bind capture_ring capture_ring_chk #(.AW(AW), .DEC_W(DEC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .decim(decim), .done(done),
  .last_addr(last_addr), .keep(keep), .wr_en(wr_en), .fire(fire),
  .filled(filled), .triggered(triggered)
);

// File: tb/test_capture_ring.sv
module test_capture_ring;
  localparam int DEPTH = 2048;
  localparam int HALF  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic [11:0] trig_level = 12'd2000;
  logic [10:0] decim = 11'd1;
  logic [10:0] rd_addr = '0;
  logic [11:0] rd_data;
  logic        done;
  logic [10:0] last_addr;

  capture_ring i_capture_ring (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .trig_level(trig_level), .decim(decim), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .last_addr(last_addr)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          chk;
    logic [11:0] val;
  } item_t;
  item_t q[$];

  int n_chk = 0;
  int n_fail = 0;

  // Bench model, kept in write counts rather than pointers.
  logic [11:0] m_mem [DEPTH];
  bit          m_ok  [DEPTH];
  int          m_writes, m_phase, m_post, m_prev, m_last;
  bit          m_trig, m_done;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_writes = 0; m_phase = 0; m_post = 0; m_prev = 0; m_last = 0;
    m_trig = 0; m_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    q.push_back('{chk: 1'b0, val: '0});
    model_reset();
    @(posedge clk); #3;
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
  endtask

  // Driver: one cycle of stimulus, one scoreboard entry, then the model step.
  task automatic step(input bit v, input logic [11:0] s, input logic [10:0] ra);
    int eff;
    bit keep;
    @(negedge clk);
    rst = 1'b0; in_valid = v; in_sample = s; rd_addr = ra;
    q.push_back('{chk: m_ok[ra], val: m_mem[ra]});
    if (v) begin
      eff  = (int'(decim) < 2) ? 1 : int'(decim);
      keep = (m_phase == 0);
      m_phase = (m_phase + 1) % eff;
      if (keep && !m_done) begin
        m_mem[m_writes % DEPTH] = s;
        m_ok[m_writes % DEPTH]  = 1'b1;
        m_last = m_writes % DEPTH;
        if (m_trig) begin
          m_post++;
          if (m_post == HALF) m_done = 1'b1;
        end else if (m_writes >= DEPTH && m_prev < int'(trig_level) &&
                     int'(s) >= int'(trig_level)) begin
          m_trig = 1'b1;
          m_post = 0;
        end
        m_writes++;
        m_prev = int'(s);
      end
    end
  endtask

  // Monitor: pops one entry per clock and compares against the design.
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk)
          check(rd_data === it.val, "R10 read data", int'(rd_data), int'(it.val));
        if (!rst) begin
          check(done === m_done, "R8 done timing", int'(done), int'(m_done));
          if (m_done)
            check(last_addr == 11'(m_last), "R9 last address", int'(last_addr), m_last);
        end
      end
    end
  end

  function automatic logic [11:0] gen(input int k, input int t, input int lvl, input bit hold);
    if (hold && k >= 2040 && k <= 2049) return 12'(lvl + 10 + (k % 5));
    if (k == t - 1) return 12'(lvl - 1);
    if (k == t) return 12'(lvl);
    if (k == 499) return 12'(lvl - 1);
    if (k == 500) return 12'(lvl);
    return 12'((k * 13) % 1500);
  endfunction

  // Feeds samples until the model reports completion; mode 1 = collision reads.
  task automatic run_capture(input int t, input bit hold, input bit collide, input bit gaps);
    int vi = 0;
    int eff = (int'(decim) < 2) ? 1 : int'(decim);
    logic [10:0] ra;
    for (int j = 0; j < 60000 && !m_done; j++) begin
      ra = collide ? 11'(m_writes % DEPTH) : 11'((j * 7) % DEPTH);
      if (gaps && (j % 4 == 3)) begin
        step(1'b0, 12'd4000, ra);
      end else begin
        if (vi % eff == 0) step(1'b1, gen(vi / eff, t, int'(trig_level), hold), ra);
        else step(1'b1, 12'(int'(trig_level) + 100), ra);
        vi++;
      end
    end
  endtask

  task automatic read_all();
    for (int a = 0; a < DEPTH; a++) step(1'b0, '0, 11'(a));
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin m_ok[a] = 1'b0; m_mem[a] = '0; end
    model_reset();

    // Full rate, early crossing ignored (R6), trigger at kept index 3000 (R3, R4, R5, R7).
    decim = 11'd1; trig_level = 12'd2000;
    do_reset();
    run_capture(3000, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, '0); step(1'b0, '0, '0);
    check(done == 1'b1, "R8 done after capture", int'(done), 1);
    check(last_addr == 11'd1976, "R9 trigger 952 plus 1024", int'(last_addr), 1976);
    for (int j = 0; j < 40; j++) step(1'b1, 12'd4095, 11'(j));
    check(last_addr == 11'd1976, "R11 last address frozen", int'(last_addr), 1976);
    read_all();
    check(m_ok[1976] && m_mem[1976] == gen(4024, 3000, 2000, 1'b0), "R11 final word intact",
          int'(m_mem[1976]), int'(gen(4024, 3000, 2000, 1'b0)));

    // Decimate by 3 with valid gaps and same-address reads (R2, R10).
    decim = 11'd3; trig_level = 12'd2000;
    do_reset();
    check(last_addr == 11'd0, "R1 pointer cleared", int'(last_addr), 0);
    run_capture(2600, 1'b0, 1'b1, 1'b1);
    step(1'b0, '0, '0); step(1'b0, '0, '0);
    check(done == 1'b1, "R2 decimated capture completes", int'(done), 1);
    check(last_addr == 11'd1576, "R9 decimated last address", int'(last_addr), 1576);
    read_all();

    // Setting 0 keeps all; held-high region shows prev at level does not fire (R3, R5, R6).
    decim = 11'd0; trig_level = 12'd3000;
    do_reset();
    run_capture(2700, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, '0); step(1'b0, '0, '0);
    check(done == 1'b1, "R3 setting zero completes", int'(done), 1);
    check(last_addr == 11'd1676, "R5 trigger at 2700 gives 1676", int'(last_addr), 1676);
    read_all();

    // Re-arm check (R1).
    do_reset();
    step(1'b0, '0, '0);
    check(done == 1'b0, "R1 re-armed", int'(done), 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule